// File: doc/BRIEF.md
# RGB565 Pulse-Width LED Colour Driver

This block turns a 16-bit colour word, packed five bits red, six bits green and five bits blue, into three one-bit pulse-width-modulated drive lines for a common-cathode RGB LED. A logic 1 on a line lights that LED element. Each colour field becomes an 8-bit duty value. The field sits in the upper bits of that value and the remaining low bits are zero.

Each channel has a free-running counter that steps through 0 to 254 and then wraps, so one PWM period lasts 255 clocks. The channel output is high while the counter is below the duty value. At a 100 MHz clock the period is 2550 ns, or about 392 kHz, which is well above visible flicker. The colour word is registered once before use, and each channel output is registered. A second three-bit LED output is held dark.

Top module: `rgb565_pwm_top`

## Requirements
- R1: `sw_word` bits 15:11 set red, bits 10:5 set green and bits 4:0 set blue. `led_main` bit 2 is red, bit 1 is green and bit 0 is blue.
- R2: The 5-bit fields for red and blue and the 6-bit field for green each fill the top bits of an 8-bit duty value, and the low bits are zero. For example, an all-ones red field gives duty 248, and the red line is high for 248 of every 255 clocks.
- R3: Each channel counter counts 0, 1, …, 254 and then returns to 0, giving a period of 255 clocks.
- R4: After each clock edge outside reset, a channel line equals (counter value before that edge < duty value before that edge).
- R5: A field of zero keeps its line low for the whole period.
- R6: While synchronous active-high `rst` is sampled high, the counters and the registered colour word clear to 0 and every output reads 0 after that edge.
- R7: The three channel counters always hold the same value, so channels with equal duty switch on the same cycle.
- R8: `sw_word` is captured by a register, so a new word first affects `led_main` on the second rising edge after it is applied.
- R9: `led_aux` is always 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_word | input | 16 | Packed 5-6-5 colour word |
| led_main | output | 3 | PWM drive {red, green, blue}, 1 = lit |
| led_aux | output | 3 | Second LED, held dark |

## Verification
There are two register stages between `sw_word` and `led_main`. A word applied before edge k is captured at edge k, and the compare that uses it appears after edge k+1. The counter value that is compared is the one held before the output edge.

The bench keeps a cycle model of these same stages. It changes inputs and reads outputs only on falling edges, so every comparison falls half a clock after the edge that produced the output. Checks on the on-time count every high cycle over a full 255-cycle window, but only after a word has been held for more than two clocks. Because the window covers a whole period, the result does not depend on where in the period the window starts.

// File: rtl/rgb565_pwm_pkg.sv
package rgb565_pwm_pkg;
  // Per-channel resolution and field widths
  localparam int DUTY_W  = 8;
  localparam int RED_W   = 5;
  localparam int GRN_W   = 6;
  localparam int BLU_W   = 5;
  localparam int WORD_W  = RED_W + GRN_W + BLU_W;
  localparam int N_CHAN  = 3;
  // Counter runs 0 .. PERIOD-1
  localparam int PERIOD  = (1 << DUTY_W) - 1;

  // Channel index: 0 = blue, 1 = green, 2 = red
  function automatic int field_width(input int ch);
    return (ch == 2) ? RED_W : (ch == 1) ? GRN_W : BLU_W;
  endfunction

  function automatic int field_low(input int ch);
    return (ch == 0) ? 0 : (ch == 1) ? BLU_W : (BLU_W + GRN_W);
  endfunction

  typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/rgb565_field_unpack.sv
module rgb565_field_unpack
  import rgb565_pwm_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int DW = DUTY_W,
  parameter int NC = N_CHAN
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WW-1:0]        word_in,
  output logic [NC-1:0][DW-1:0] duty_out
);
  logic [WW-1:0] word_q;

  // Single capture stage so a word change never splits a compare
  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= word_in;
  end

  for (genvar ch = 0; ch < NC; ch++) begin : g_fld
    localparam int FW = field_width(ch);
    localparam int LO = field_low(ch);
    if (FW >= DW) begin : g_full
      assign duty_out[ch] = word_q[LO+FW-1 -: DW];
    end else begin : g_pad
      assign duty_out[ch] = {word_q[LO+FW-1 -: FW], {(DW-FW){1'b0}}};
    end
  end
endmodule

// File: rtl/pwm_wrap_counter.sv
module pwm_wrap_counter #(
  parameter int W      = 8,
  parameter int PERIOD = 255
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_threshold_out.sv
module pwm_threshold_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] duty,
  output logic         drive
);
  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= (cnt < duty);
  end
endmodule

// File: rtl/rgb565_pwm_top.sv
module rgb565_pwm_top
  import rgb565_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] sw_word,
  output logic [N_CHAN-1:0] led_main,
  output logic [N_CHAN-1:0] led_aux
);
  logic [N_CHAN-1:0][DUTY_W-1:0] chan_duty;
  logic [N_CHAN-1:0][DUTY_W-1:0] chan_count;

  rgb565_field_unpack #(
    .WW(WORD_W), .DW(DUTY_W), .NC(N_CHAN)
  ) u_unpack (
    .clk(clk), .rst(rst), .word_in(sw_word), .duty_out(chan_duty)
  );

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    pwm_wrap_counter #(.W(DUTY_W), .PERIOD(PERIOD)) u_cnt (
      .clk(clk), .rst(rst), .cnt(chan_count[ch])
    );
    pwm_threshold_out #(.W(DUTY_W)) u_cmp (
      .clk(clk), .rst(rst), .cnt(chan_count[ch]),
      .duty(chan_duty[ch]), .drive(led_main[ch])
    );
  end

  assign led_aux = '0;
endmodule

// File: rtl/rgb565_pwm_chk.sv
module rgb565_pwm_chk
  import rgb565_pwm_pkg::*;
(
  input logic                          clk,
  input logic                          rst,
  input logic [N_CHAN-1:0]             led_main,
  input logic [N_CHAN-1:0][DUTY_W-1:0] chan_count,
  input logic [N_CHAN-1:0][DUTY_W-1:0] chan_duty
);
  localparam logic [DUTY_W-1:0] LAST = DUTY_W'(PERIOD - 1);

  // R6
  reset_dark_chk: assert property (@(posedge clk) rst |=> led_main == '0);

  // R7
  lockstep_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_count[0] == chan_count[1]) && (chan_count[1] == chan_count[2]));

  // R3
  count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_count[0] == LAST) |=> (chan_count[0] == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_count[0] != LAST) |=> (chan_count[0] == $past(chan_count[0]) + 1'b1));

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    chan_count[0] <= LAST);

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_a
    // R4
    drive_match_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (led_main[ch] == ($past(chan_count[ch]) < $past(chan_duty[ch]))));
    // R5
    zero_dark_chk: assert property (@(posedge clk) disable iff (rst)
      (chan_duty[ch] == '0) |=> !led_main[ch]);
  end
endmodule

bind rgb565_pwm_top rgb565_pwm_chk u_chk (
  .clk(clk), .rst(rst), .led_main(led_main),
  .chan_count(chan_count), .chan_duty(chan_duty)
);

// File: tb/tb_rgb565_pwm_top.sv
module tb_rgb565_pwm_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw_word = 16'h0000;
  logic [2:0]  led_main;
  logic [2:0]  led_aux;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rgb565_pwm_top dut (
    .clk(clk), .rst(rst), .sw_word(sw_word),
    .led_main(led_main), .led_aux(led_aux)
  );

  // Duty values from requirements R1/R2
  function automatic logic [7:0] duty_red(input logic [15:0] w);
    return {w[15:11], 3'b000};
  endfunction
  function automatic logic [7:0] duty_grn(input logic [15:0] w);
    return {w[10:5], 2'b00};
  endfunction
  function automatic logic [7:0] duty_blu(input logic [15:0] w);
    return {w[4:0], 3'b000};
  endfunction

  // Cycle model per R3, R4, R6, R8
  int          m_cnt = 0;
  logic [15:0] m_sw  = '0;
  logic [2:0]  m_out = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_sw = '0; m_out = '0;
    end else begin
      m_out = {m_cnt < int'(duty_red(m_sw)), m_cnt < int'(duty_grn(m_sw)),
               m_cnt < int'(duty_blu(m_sw))};
      m_cnt = (m_cnt == 254) ? 0 : m_cnt + 1;
      m_sw  = sw_word;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: sample at negedge against model, also led_aux
  task automatic step_cmp(input string req);
    @(negedge clk);
    check(led_main == m_out, req, int'(led_main), int'(m_out));
    check(led_aux == 3'b000, "R9", int'(led_aux), 0);
  endtask

  // Count high cycles per channel over one full period
  task automatic period_count(input logic [15:0] w, input string req);
    int hr, hg, hb;
    sw_word = w;
    for (int i = 0; i < 3; i++) step_cmp(req);
    hr = 0; hg = 0; hb = 0;
    for (int i = 0; i < 255; i++) begin
      step_cmp(req);
      hr += led_main[2]; hg += led_main[1]; hb += led_main[0];
    end
    check(hr == int'(duty_red(w)), {req, " red"}, hr, int'(duty_red(w)));
    check(hg == int'(duty_grn(w)), {req, " green"}, hg, int'(duty_grn(w)));
    check(hb == int'(duty_blu(w)), {req, " blue"}, hb, int'(duty_blu(w)));
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    // R6: outputs dark during reset
    check(led_main == 3'b000, "R6", int'(led_main), 0);
    check(led_aux == 3'b000, "R9", int'(led_aux), 0);
    sw_word = 16'hFFFF;
    @(negedge clk);
    check(led_main == 3'b000, "R6", int'(led_main), 0);
    rst = 1'b0;

    // R2 / R1: field placement and padding
    period_count(16'hF800, "R2");
    period_count(16'h07E0, "R1");
    period_count(16'h001F, "R1");
    // R5: zero fields
    period_count(16'h0000, "R5");
    period_count(16'h8411, "R2");

    // R7: equal duties switch together (red 1, green 2, blue 1 -> all 8)
    sw_word = 16'h0841;
    for (int i = 0; i < 3; i++) step_cmp("R7");
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      check(led_main == 3'b000 || led_main == 3'b111, "R7", int'(led_main), 7);
    end

    // R8: mid-period change appears on second edge
    sw_word = 16'h0000;
    for (int i = 0; i < 20; i++) step_cmp("R8");
    sw_word = 16'hFFFF;
    @(negedge clk);
    check(led_main == 3'b000, "R8", int'(led_main), 0);
    @(negedge clk);
    check(led_main == m_out, "R8", int'(led_main), int'(m_out));
    check(led_main == 3'b111, "R8", int'(led_main), 7);

    // R3 / R4: random words with random hold times
    for (int k = 0; k < 40; k++) begin
      sw_word = 16'($urandom);
      for (int i = 0; i < int'($urandom_range(1, 300)); i++) step_cmp("R4");
    end

    // R6: reset mid-run then restart
    rst = 1'b1;
    @(negedge clk);
    check(led_main == 3'b000, "R6", int'(led_main), 0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 600; i++) step_cmp("R3");
    period_count(16'hFFFF, "R2");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule